// File: doc/BRIEF.md
# Register-Mapped Multiply/Divide Coprocessor

A small arithmetic unit that sits on an 8-bit CPU bus and offers an unsigned 8x8 multiply and an unsigned 16-by-8 divide. Software writes operand bytes into write-only registers. The write that delivers the last operand (the multiplier or the divisor) starts the operation. When `busy_o` falls, software reads the 16-bit quotient and a shared 16-bit product/remainder register back as byte pairs.

The multiply runs as an 8-step shift-add and the divide as a 16-step restoring division, one step per clock. The block keeps two behaviours on purpose. A multiply overwrites the quotient register with its multiplier byte. A zero divisor produces an all-ones quotient and leaves the dividend as the remainder. The second one follows from the restoring steps themselves, with no special case in the logic.

Top module: `arith_copro`

## Requirements
- R1: Writing offset 0x03 starts a multiply of the byte latched at offset 0x02 (multiplicand) by the written byte (multiplier). The unsigned 16-bit product then reads back with its low byte at offset 0x16 and its high byte at offset 0x17.
- R2: On completion, a multiply loads the quotient register with its multiplier, zero-extended. Offset 0x14 reads the multiplier and offset 0x15 reads 0.
- R3: Offsets 0x04 and 0x05 hold the low and high byte of the dividend. Writing offset 0x06 starts a divide by the written byte. The quotient then reads back low/high at 0x14/0x15 and the remainder at 0x16/0x17.
- R4: A divide by zero yields quotient 0xFFFF, and the remainder equals the dividend.
- R5: A write to one dividend byte leaves the other dividend byte unchanged.
- R6: `busy_o` rises on the clock edge that takes the start write. It stays high for exactly 8 cycles for a multiply and 16 cycles for a divide. The results are updated on the edge where it falls.
- R7: A start write while `busy_o` is high abandons the running operation. The new operation restarts with a full step count and the newly latched operands.
- R8: Reads of the operand offsets 0x02 to 0x06, and of any unmapped offset, return 0. Writes to offsets 0x14 to 0x17 have no effect on the results.
- R9: After reset, `busy_o` is low and all result registers and operand latches read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe, sampled on the rising clock edge |
| addr_i | input | 5 | Register offset for reads and writes |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data byte, a combinational function of `addr_i` |
| busy_o | output | 1 | High while a multiply or divide is in progress |

## Verification
A wrong step count or a corrupted partial product shows up at the ports in two ways. `busy_o` falls on the wrong cycle, which the bench measures to the exact cycle against 8 or 16. Or the product/remainder bytes differ from the reference as soon as `busy_o` falls. A fault in the quotient shift path shows in the quotient bytes of the very next divide. The zero-divisor vectors expose it at once as a value other than 0xFFFF. A dividend latch that clobbers its neighbour byte produces a wrong quotient on the first divide after a single-byte update.

// File: rtl/copro_pkg.sv
package copro_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_MCAND   = 5'h02;
  localparam logic [ADDR_W-1:0] OFS_MPLIER  = 5'h03;
  localparam logic [ADDR_W-1:0] OFS_DVD_LO  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_DVD_HI  = 5'h05;
  localparam logic [ADDR_W-1:0] OFS_DIVISOR = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_QUOT_LO = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_QUOT_HI = 5'h15;
  localparam logic [ADDR_W-1:0] OFS_RES_LO  = 5'h16;
  localparam logic [ADDR_W-1:0] OFS_RES_HI  = 5'h17;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL,
    ST_DIV
  } seq_state_e;
endpackage

// File: rtl/copro_decode.sv
module copro_decode
  import copro_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     mcand_o,
  output logic [2*DATA_W-1:0]   dividend_o,
  output logic                  mul_start_o,
  output logic                  div_start_o
);
  localparam int unsigned WIDE_W = 2 * DATA_W;

  logic [DATA_W-1:0] mcand_q;
  logic [WIDE_W-1:0] dvd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      dvd_q   <= '0;
    end else if (wr_en_i) begin
      if (addr_i == OFS_MCAND)  mcand_q <= wdata_i;
      if (addr_i == OFS_DVD_LO) dvd_q[DATA_W-1:0] <= wdata_i;
      if (addr_i == OFS_DVD_HI) dvd_q[WIDE_W-1:DATA_W] <= wdata_i;
    end
  end

  assign mcand_o     = mcand_q;
  assign dividend_o  = dvd_q;
  assign mul_start_o = wr_en_i && (addr_i == OFS_MPLIER);
  assign div_start_o = wr_en_i && (addr_i == OFS_DIVISOR);

  // R5: a single-byte dividend write keeps the other byte
  a_r5_lo_keeps_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_DVD_LO) |=> dvd_q[WIDE_W-1:DATA_W] == $past(dvd_q[WIDE_W-1:DATA_W]));
  a_r5_hi_keeps_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_DVD_HI) |=> dvd_q[DATA_W-1:0] == $past(dvd_q[DATA_W-1:0]));
endmodule

// File: rtl/copro_mul_step.sv
module copro_mul_step #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] mcand_i,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o
);
  logic [DATA_W:0] sum;

  always_comb begin
    sum = {1'b0, hi_i} + {1'b0, (lo_i[0] ? mcand_i : {DATA_W{1'b0}})};
    {hi_o, lo_o} = {sum, lo_i[DATA_W-1:1]};
  end
endmodule

// File: rtl/copro_div_step.sv
module copro_div_step #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [2*DATA_W-1:0] rem_i,
  input  logic [2*DATA_W-1:0] dvd_i,
  input  logic [DATA_W-1:0]   divisor_i,
  output logic [2*DATA_W-1:0] rem_o,
  output logic [2*DATA_W-1:0] dvd_o
);
  localparam int unsigned WIDE_W = 2 * DATA_W;

  logic [WIDE_W:0] trial;
  logic [WIDE_W:0] dsr_ext;
  logic [WIDE_W:0] diff;
  logic            qbit;

  always_comb begin
    trial   = {rem_i, dvd_i[WIDE_W-1]};
    dsr_ext = {{(DATA_W+1){1'b0}}, divisor_i};
    diff    = trial - dsr_ext;
    qbit    = (trial >= dsr_ext);
    // zero divisor: every step restores nothing, so quotient fills with ones
    rem_o   = qbit ? diff[WIDE_W-1:0] : trial[WIDE_W-1:0];
    dvd_o   = {dvd_i[WIDE_W-2:0], qbit};
  end
endmodule

// File: rtl/copro_core.sv
module copro_core
  import copro_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mul_start_i,
  input  logic                  div_start_i,
  input  logic [DATA_W-1:0]     opnd_i,
  input  logic [DATA_W-1:0]     mcand_i,
  input  logic [2*DATA_W-1:0]   dividend_i,
  output logic                  busy_o,
  output logic [2*DATA_W-1:0]   quot_o,
  output logic [2*DATA_W-1:0]   res_o
);
  localparam int unsigned WIDE_W = 2 * DATA_W;
  localparam int unsigned CNT_W  = $clog2(WIDE_W + 1);
  localparam logic [CNT_W-1:0] MUL_CNT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] DIV_CNT = CNT_W'(WIDE_W);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WIDE_W-1:0] work_a_q;   // mul: {hi,lo} product; div: partial remainder
  logic [WIDE_W-1:0] work_b_q;   // div: dividend shifting out, quotient shifting in
  logic [DATA_W-1:0] arg_q;      // mul: multiplicand; div: divisor
  logic [DATA_W-1:0] mplier_q;
  logic [WIDE_W-1:0] quot_q;
  logic [WIDE_W-1:0] res_q;

  logic [DATA_W-1:0] mul_hi, mul_lo;
  logic [WIDE_W-1:0] div_rem, div_dvd;
  logic              last_step;
  logic              any_start;

  copro_mul_step #(.DATA_W(DATA_W)) u_mul_step (
    .hi_i   (work_a_q[WIDE_W-1:DATA_W]),
    .lo_i   (work_a_q[DATA_W-1:0]),
    .mcand_i(arg_q),
    .hi_o   (mul_hi),
    .lo_o   (mul_lo)
  );

  copro_div_step #(.DATA_W(DATA_W)) u_div_step (
    .rem_i    (work_a_q),
    .dvd_i    (work_b_q),
    .divisor_i(arg_q),
    .rem_o    (div_rem),
    .dvd_o    (div_dvd)
  );

  assign last_step = (cnt_q == CNT_W'(1));
  assign any_start = mul_start_i || div_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      work_a_q <= '0;
      work_b_q <= '0;
      arg_q    <= '0;
      mplier_q <= '0;
      quot_q   <= '0;
      res_q    <= '0;
    end else if (mul_start_i) begin
      state_q  <= ST_MUL;
      cnt_q    <= MUL_CNT;
      work_a_q <= {{DATA_W{1'b0}}, opnd_i};
      arg_q    <= mcand_i;
      mplier_q <= opnd_i;
    end else if (div_start_i) begin
      state_q  <= ST_DIV;
      cnt_q    <= DIV_CNT;
      work_a_q <= '0;
      work_b_q <= dividend_i;
      arg_q    <= opnd_i;
    end else begin
      unique case (state_q)
        ST_MUL: begin
          work_a_q <= {mul_hi, mul_lo};
          cnt_q    <= cnt_q - CNT_W'(1);
          if (last_step) begin
            state_q <= ST_IDLE;
            res_q   <= {mul_hi, mul_lo};
            quot_q  <= {{DATA_W{1'b0}}, mplier_q};
          end
        end
        ST_DIV: begin
          work_a_q <= div_rem;
          work_b_q <= div_dvd;
          cnt_q    <= cnt_q - CNT_W'(1);
          if (last_step) begin
            state_q <= ST_IDLE;
            quot_q  <= div_dvd;
            res_q   <= div_rem;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign quot_o = quot_q;
  assign res_o  = res_q;

  a_r6_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_start |=> busy_o);
  a_r6_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q != '0 && cnt_q <= DIV_CNT));
  a_r7_restart_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mul_start_i) |=> (cnt_q == MUL_CNT));
  a_r2_quot_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MUL && last_step && !any_start) |=> (!busy_o && quot_q[WIDE_W-1:DATA_W] == '0));
  a_r4_zero_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIV && last_step && !any_start && arg_q == '0) |=> (quot_q == '1));
endmodule

// File: rtl/arith_copro.sv
module arith_copro
  import copro_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o
);
  localparam int unsigned WIDE_W = 2 * DATA_W;

  logic [DATA_W-1:0] mcand;
  logic [WIDE_W-1:0] dividend;
  logic              mul_start, div_start;
  logic [WIDE_W-1:0] quot, res;

  copro_decode #(.DATA_W(DATA_W)) u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mcand_o    (mcand),
    .dividend_o (dividend),
    .mul_start_o(mul_start),
    .div_start_o(div_start)
  );

  copro_core #(.DATA_W(DATA_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mul_start_i(mul_start),
    .div_start_i(div_start),
    .opnd_i     (wdata_i),
    .mcand_i    (mcand),
    .dividend_i (dividend),
    .busy_o     (busy_o),
    .quot_o     (quot),
    .res_o      (res)
  );

  always_comb begin
    unique case (addr_i)
      OFS_QUOT_LO: rdata_o = quot[DATA_W-1:0];
      OFS_QUOT_HI: rdata_o = quot[WIDE_W-1:DATA_W];
      OFS_RES_LO:  rdata_o = res[DATA_W-1:0];
      OFS_RES_HI:  rdata_o = res[WIDE_W-1:DATA_W];
      default:     rdata_o = '0;
    endcase
  end

  // R8: result-offset writes must leave results untouched when idle
  a_r8_result_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !busy_o && addr_i >= OFS_QUOT_LO && addr_i <= OFS_RES_HI)
      |=> ($stable(quot) && $stable(res)));
endmodule

// File: tb/arith_copro_test.sv
module arith_copro_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       busy_o;

  int errors = 0;
  int checks = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  arith_copro uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .busy_o (busy_o)
  );

  // op: 0 = multiply (a = multiplicand), 1 = divide (a = dividend)
  localparam int NVEC = 13;
  localparam int VOP[NVEC] = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 1};
  localparam int VA [NVEC] = '{10, 0, 1, 255, 165, 12, 10, 65535, 65500, 123, 'h1234, 7, 65535};
  localparam int VB [NVEC] = '{12, 12, 12, 255, 60, 10, 10, 255, 255, 0, 0, 9, 1};

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd16(input logic [4:0] lo_addr, output int v);
    int lo;
    addr_i = lo_addr; #1; lo = int'(rdata_o);
    addr_i = lo_addr + 5'd1; #1;
    v = (int'(rdata_o) << 8) | lo;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int q, r, n, eq, er;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 reset state
    check("R9 busy", int'(busy_o), 0);
    rd16(5'h14, q); check("R9 quotient", q, 0);
    rd16(5'h16, r); check("R9 result", r, 0);
    wr(5'h03, 8'd12); wait_idle(n);
    rd16(5'h16, r); check("R9 multiplicand latch zero", r, 0);
    wr(5'h06, 8'd3); wait_idle(n);
    rd16(5'h14, q); check("R9 dividend latch zero", q, 0);

    // vector table: R1 R2 R3 R4
    for (int i = 0; i < NVEC; i++) begin
      if (VOP[i] == 0) begin
        wr(5'h02, 8'(VA[i]));
        wr(5'h03, 8'(VB[i]));
        wait_idle(n);
        check("R6 multiply busy cycles", n, 8);
        rd16(5'h16, r); check("R1 product", r, VA[i] * VB[i]);
        rd16(5'h14, q); check("R2 quotient overwritten by multiplier", q, VB[i]);
      end else begin
        wr(5'h04, 8'(VA[i] & 'hFF));
        wr(5'h05, 8'(VA[i] >> 8));
        wr(5'h06, 8'(VB[i]));
        wait_idle(n);
        check("R6 divide busy cycles", n, 16);
        if (VB[i] == 0) begin eq = 'hFFFF; er = VA[i]; end
        else begin eq = VA[i] / VB[i]; er = VA[i] % VB[i]; end
        rd16(5'h14, q); check(VB[i] == 0 ? "R4 zero-divisor quotient" : "R3 quotient", q, eq);
        rd16(5'h16, r); check(VB[i] == 0 ? "R4 zero-divisor remainder" : "R3 remainder", r, er);
      end
    end

    // R5 byte-wise dividend update
    wr(5'h04, 8'h34); wr(5'h05, 8'h12); wr(5'h04, 8'h78);
    wr(5'h06, 8'd1); wait_idle(n);
    rd16(5'h14, q); check("R5 low write keeps high", q, 'h1278);
    wr(5'h05, 8'hAB);
    wr(5'h06, 8'd1); wait_idle(n);
    rd16(5'h14, q); check("R5 high write keeps low", q, 'hAB78);

    // R7 restart: divide abandoned by a multiply
    wr(5'h04, 8'hE8); wr(5'h05, 8'h03); wr(5'h02, 8'd20);
    wr(5'h06, 8'd7);
    repeat (3) @(negedge clk_i);
    wr(5'h03, 8'd30); wait_idle(n);
    check("R7 restart busy cycles", n, 8);
    rd16(5'h16, r); check("R7 restart product", r, 600);
    rd16(5'h14, q); check("R7 restart quotient", q, 30);
    // R7 restart: multiply abandoned by a divide
    wr(5'h03, 8'd99);
    @(negedge clk_i);
    wr(5'h06, 8'd7); wait_idle(n);
    check("R7 restart divide busy cycles", n, 16);
    rd16(5'h14, q); check("R7 restart divide quotient", q, 1000 / 7);
    rd16(5'h16, r); check("R7 restart divide remainder", r, 1000 % 7);

    // R8 operand/unmapped reads and result-write immunity
    for (int a = 2; a <= 6; a++) begin
      addr_i = 5'(a); #1; check("R8 operand offset reads zero", int'(rdata_o), 0);
    end
    addr_i = 5'h00; #1; check("R8 unmapped reads zero", int'(rdata_o), 0);
    addr_i = 5'h1F; #1; check("R8 unmapped reads zero", int'(rdata_o), 0);
    for (int a = 'h14; a <= 'h17; a++) wr(5'(a), 8'h5A);
    rd16(5'h14, q); check("R8 quotient unchanged", q, 1000 / 7);
    rd16(5'h16, r); check("R8 remainder unchanged", r, 1000 % 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule